// File: doc/BRIEF.md
# SMBus Host Register Bank

This block is the software-facing register file of a PC-style SMBus host controller. Software reaches it through single-byte reads and writes on a small synchronous bus. It holds the status, control, command, address, two data bytes, a block data byte and an auxiliary control byte. The control and data fields are exposed as configuration outputs toward a separate transaction engine. The bank sends a one-cycle start pulse to that engine. The engine reports completion, errors, returned data and block progress back through event inputs, and the bank merges those events into its own state.

The bank drives a level interrupt that follows the status and control registers. The status register is cleared by writing ones to it, but the host-busy flag is owned by the start, kill and engine paths, so a status write cannot clear it. A control write carrying the kill bit aborts the current operation: it marks the operation failed and done, drops busy and rewinds the block index. The sequencing of bus transactions, the storage of block payloads and the physical SMBus pins all live outside this block.

Top module: `smbh_regbank`

## Requirements
- R1: After reset the status register reads 0x00, `irq` and `start_pulse` are 0, `blk_idx` is 0 and `op_done` is 1.
- R2: A read returns its byte on `bus_rdata` in the cycle after `bus_rd`. The mapped offsets are 0x00 status, 0x02 control, 0x03 command, 0x04 address, 0x05 data0, 0x06 data1, 0x07 block data and 0x0D auxiliary control. A read of any other offset returns 0x00.
- R3: A write to status offset 0x00 clears every status bit written as 1, except bit 0 (host busy), which such a write never changes. The status bits are: 0 busy, 1 interrupt, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in-use, 7 byte done.
- R4: When an `eng_set` bit and a software write of 1 to the same status bit fall in the same cycle, the bit ends up set.
- R5: Control bit 6 (start) is never stored. The control offset reads back only bits 4:0. These are bit 0 interrupt enable, bit 1 kill and bits 4:2 protocol; bit 5 is last byte and bit 7 is PEC enable. A control write with bit 6 set produces `start_pulse` high for exactly the following cycle. In that same update it sets host busy, clears `op_done` and zeroes `blk_idx`.
- R6: Every control write with bit 1 (kill) set sets status bit 4 (failed), clears host busy, zeroes `blk_idx` and sets `op_done`. This takes precedence over a start in the same write.
- R7: `irq` is 1 exactly when control bit 0 is set and any of status bits 7:1 is set. Host busy alone never raises it. It reflects the state after each access.
- R8: The auxiliary control offset keeps only bits 1:0 (bit 0 PEC, bit 1 block-buffer mode) and reads the rest as 0.
- R9: `eng_dsel` bits 0, 1 and 2 load `eng_dat` into data0, data1 and block data. An engine load takes precedence over a software write to the same register in the same cycle.
- R10: Each `eng_idx_step` pulse advances `blk_idx` by one, wrapping from BUF_DEPTH-1 to 0.
- R11: `eng_busy_clr` clears host busy. `eng_done` sets `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt |
| start_pulse | output | 1 | One-cycle start request to the engine |
| cfg_prot | output | 3 | Protocol selector from control |
| cfg_last | output | 1 | Last-byte flag from control |
| cfg_pec_en | output | 1 | PEC enable from control |
| cfg_aux_pec | output | 1 | Auxiliary PEC bit |
| cfg_aux_blk | output | 1 | Block-buffer mode bit |
| cfg_cmd | output | 8 | Command byte |
| cfg_addr | output | 8 | Target address byte with the direction bit |
| cfg_data0 | output | 8 | Data byte 0 |
| cfg_data1 | output | 8 | Data byte 1 |
| cfg_blkdat | output | 8 | Block data byte |
| blk_idx | output | $clog2(BUF_DEPTH) | Block buffer index |
| op_done | output | 1 | Operation finished flag |
| eng_set | input | 8 | Status bits to set this cycle |
| eng_busy_clr | input | 1 | Engine clears host busy |
| eng_done | input | 1 | Engine marks the operation done |
| eng_idx_step | input | 1 | Advance block index |
| eng_dsel | input | 3 | Engine load select {block, data1, data0} |
| eng_dat | input | 8 | Engine load byte |

## Verification
The hardest state to reach is a collision: an engine event and a software access that touch the same status bit or data register in the same clock. Reaching it needs a single hand-built cycle that raises both the bus write strobe and the engine strobe together. The index wrap is another hard case, because it is reached only after a full run of step pulses. Both follow a table walk over every offset, and the kill and start side effects are each checked against the exact cycle in which they take hold.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam logic [7:0] OFF_STS  = 8'h00;
  localparam logic [7:0] OFF_CTL  = 8'h02;
  localparam logic [7:0] OFF_CMD  = 8'h03;
  localparam logic [7:0] OFF_ADR  = 8'h04;
  localparam logic [7:0] OFF_D0   = 8'h05;
  localparam logic [7:0] OFF_D1   = 8'h06;
  localparam logic [7:0] OFF_BLK  = 8'h07;
  localparam logic [7:0] OFF_AUX  = 8'h0D;

  localparam int ST_BUSY = 0;
  localparam int ST_FAIL = 4;

  localparam int CT_IEN   = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_LAST  = 5;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;

  localparam logic [7:0] CTL_RD_MASK = 8'h1F;
  localparam logic [7:0] AUX_MASK    = 8'h03;
endpackage

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_wr,
  input  logic [7:0] sw_wdata,
  input  logic       start_fx,
  input  logic       kill_fx,
  input  logic [7:0] eng_set,
  input  logic       eng_busy_clr,
  output logic [7:0] stat_q,
  output logic [7:0] stat_d
);
  always_comb begin
    stat_d = stat_q;
    if (sw_wr) stat_d = stat_d & ~(sw_wdata & ~(8'(1) << ST_BUSY));
    if (start_fx) stat_d[ST_BUSY] = 1'b1;
    if (kill_fx) begin
      stat_d[ST_FAIL] = 1'b1;
      stat_d[ST_BUSY] = 1'b0;
    end
    if (eng_busy_clr) stat_d[ST_BUSY] = 1'b0;
    stat_d = stat_d | eng_set;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= 8'h00;
    else     stat_q <= stat_d;
  end

  p_busy_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && stat_q[ST_BUSY] && !kill_fx && !eng_busy_clr) |=> stat_q[ST_BUSY]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_set != 8'h00) |=> ((stat_q & $past(eng_set)) == $past(eng_set)));

  p_kill_fail_r6: assert property (@(posedge clk) disable iff (rst)
    (kill_fx && !eng_set[ST_BUSY]) |=> (stat_q[ST_FAIL] && !stat_q[ST_BUSY]));
endmodule

// File: rtl/smbh_ctrl.sv
module smbh_ctrl
  import smbh_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUF_DEPTH = 32,
  localparam int IW       = $clog2(BUF_DEPTH)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [2:0]        eng_dsel,
  input  logic [7:0]        eng_dat,
  input  logic              eng_done,
  input  logic              eng_idx_step,
  input  logic              eng_busy_clr,
  output logic [7:0]        ctl_q,
  output logic [7:0]        cmd_q,
  output logic [7:0]        adr_q,
  output logic [7:0]        d0_q,
  output logic [7:0]        d1_q,
  output logic [7:0]        blk_q,
  output logic [1:0]        aux_q,
  output logic              sts_wr,
  output logic              start_fx,
  output logic              kill_fx,
  output logic              start_pulse,
  output logic              ien_d,
  output logic [IW-1:0]     blk_idx,
  output logic              op_done
);
  localparam logic [IW-1:0] IDX_LAST = IW'(BUF_DEPTH - 1);

  logic wr_ctl, wr_cmd, wr_adr, wr_d0, wr_d1, wr_blk, wr_aux;
  logic [7:0] ctl_d;

  always_comb begin
    sts_wr = wr && (addr == ADDR_W'(OFF_STS));
    wr_ctl = wr && (addr == ADDR_W'(OFF_CTL));
    wr_cmd = wr && (addr == ADDR_W'(OFF_CMD));
    wr_adr = wr && (addr == ADDR_W'(OFF_ADR));
    wr_d0  = wr && (addr == ADDR_W'(OFF_D0));
    wr_d1  = wr && (addr == ADDR_W'(OFF_D1));
    wr_blk = wr && (addr == ADDR_W'(OFF_BLK));
    wr_aux = wr && (addr == ADDR_W'(OFF_AUX));
    start_fx = wr_ctl && wdata[CT_START];
    kill_fx  = wr_ctl && wdata[CT_KILL];
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d = wdata;
      ctl_d[CT_START] = 1'b0;
    end
    ien_d = ctl_d[CT_IEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= 8'h00;
      cmd_q <= 8'h00;
      adr_q <= 8'h00;
      aux_q <= 2'b00;
      start_pulse <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      if (wr_cmd) cmd_q <= wdata;
      if (wr_adr) adr_q <= wdata;
      if (wr_aux) aux_q <= wdata[1:0] & AUX_MASK[1:0];
      start_pulse <= start_fx;
    end
  end

  // Data registers with engine-over-software precedence, one per select bit
  logic [7:0] dreg [3];
  logic [2:0] sw_sel;
  assign sw_sel = {wr_blk, wr_d1, wr_d0};

  for (genvar g = 0; g < 3; g++) begin : g_dreg
    always_ff @(posedge clk) begin
      if (rst)               dreg[g] <= 8'h00;
      else if (eng_dsel[g])  dreg[g] <= eng_dat;
      else if (sw_sel[g])    dreg[g] <= wdata;
    end
  end
  assign d0_q  = dreg[0];
  assign d1_q  = dreg[1];
  assign blk_q = dreg[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_idx <= '0;
      op_done <= 1'b1;
    end else if (kill_fx) begin
      blk_idx <= '0;
      op_done <= 1'b1;
    end else if (start_fx) begin
      blk_idx <= '0;
      op_done <= 1'b0;
    end else begin
      if (eng_idx_step) blk_idx <= (blk_idx == IDX_LAST) ? '0 : blk_idx + 1'b1;
      if (eng_done) op_done <= 1'b1;
    end
  end

  p_start_src_r5: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> $past(start_fx));

  p_kill_idx_r6: assert property (@(posedge clk) disable iff (rst)
    kill_fx |=> (blk_idx == '0 && op_done));

  p_idx_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (eng_idx_step && !kill_fx && !start_fx && blk_idx == IDX_LAST) |=> blk_idx == '0);

  p_busyclr_r11: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !start_fx) |=> op_done);

  logic unused_ok;
  assign unused_ok = eng_busy_clr;
endmodule

// File: rtl/smbh_rdmux.sv
module smbh_rdmux
  import smbh_pkg::*;
#(
  parameter int ADDR_W = 6
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        stat,
  input  logic [7:0]        ctl,
  input  logic [7:0]        cmd,
  input  logic [7:0]        adr,
  input  logic [7:0]        d0,
  input  logic [7:0]        d1,
  input  logic [7:0]        blk,
  input  logic [1:0]        aux,
  output logic [7:0]        rdata
);
  logic [7:0] sel;
  logic       hit;

  always_comb begin
    hit = 1'b1;
    case (addr)
      ADDR_W'(OFF_STS): sel = stat;
      ADDR_W'(OFF_CTL): sel = ctl & CTL_RD_MASK;
      ADDR_W'(OFF_CMD): sel = cmd;
      ADDR_W'(OFF_ADR): sel = adr;
      ADDR_W'(OFF_D0):  sel = d0;
      ADDR_W'(OFF_D1):  sel = d1;
      ADDR_W'(OFF_BLK): sel = blk;
      ADDR_W'(OFF_AUX): sel = {6'b0, aux};
      default: begin
        sel = 8'h00;
        hit = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 8'h00;
    else if (rd) rdata <= sel;
  end

  p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit) |=> rdata == 8'h00);

  p_ctl_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(OFF_CTL)) |=> rdata[7:5] == 3'b000);
endmodule

// File: rtl/smbh_regbank.sv
module smbh_regbank
  import smbh_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUF_DEPTH = 32,
  localparam int IW       = $clog2(BUF_DEPTH)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              start_pulse,
  output logic [2:0]        cfg_prot,
  output logic              cfg_last,
  output logic              cfg_pec_en,
  output logic              cfg_aux_pec,
  output logic              cfg_aux_blk,
  output logic [7:0]        cfg_cmd,
  output logic [7:0]        cfg_addr,
  output logic [7:0]        cfg_data0,
  output logic [7:0]        cfg_data1,
  output logic [7:0]        cfg_blkdat,
  output logic [IW-1:0]     blk_idx,
  output logic              op_done,
  input  logic [7:0]        eng_set,
  input  logic              eng_busy_clr,
  input  logic              eng_done,
  input  logic              eng_idx_step,
  input  logic [2:0]        eng_dsel,
  input  logic [7:0]        eng_dat
);
  logic [7:0] ctl_q, cmd_q, adr_q, d0_q, d1_q, blk_q, stat_q, stat_d;
  logic [1:0] aux_q;
  logic sts_wr, start_fx, kill_fx, ien_d;

  smbh_ctrl #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .eng_dsel(eng_dsel), .eng_dat(eng_dat), .eng_done(eng_done),
    .eng_idx_step(eng_idx_step), .eng_busy_clr(eng_busy_clr),
    .ctl_q(ctl_q), .cmd_q(cmd_q), .adr_q(adr_q), .d0_q(d0_q), .d1_q(d1_q),
    .blk_q(blk_q), .aux_q(aux_q), .sts_wr(sts_wr), .start_fx(start_fx),
    .kill_fx(kill_fx), .start_pulse(start_pulse), .ien_d(ien_d),
    .blk_idx(blk_idx), .op_done(op_done)
  );

  smbh_status u_status (
    .clk(clk), .rst(rst), .sw_wr(sts_wr), .sw_wdata(bus_wdata),
    .start_fx(start_fx), .kill_fx(kill_fx), .eng_set(eng_set),
    .eng_busy_clr(eng_busy_clr), .stat_q(stat_q), .stat_d(stat_d)
  );

  smbh_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .stat(stat_q),
    .ctl(ctl_q), .cmd(cmd_q), .adr(adr_q), .d0(d0_q), .d1(d1_q),
    .blk(blk_q), .aux(aux_q), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ien_d && (stat_d[7:1] != 7'h00);
  end

  assign cfg_prot    = ctl_q[4:2];
  assign cfg_last    = ctl_q[CT_LAST];
  assign cfg_pec_en  = ctl_q[CT_PEC];
  assign cfg_aux_pec = aux_q[0];
  assign cfg_aux_blk = aux_q[1];
  assign cfg_cmd     = cmd_q;
  assign cfg_addr    = adr_q;
  assign cfg_data0   = d0_q;
  assign cfg_data1   = d1_q;
  assign cfg_blkdat  = blk_q;

  p_irq_match_r7: assert property (@(posedge clk) disable iff (rst)
    irq == (ctl_q[CT_IEN] && (stat_q[7:1] != 7'h00)));

  p_busy_noirq_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_q[7:1] == 7'h00) |-> !irq);

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (stat_q == 8'h00 && !irq && op_done && blk_idx == '0));
endmodule

// File: tb/smbh_regbank_test.sv
module smbh_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 32;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic irq, start_pulse, cfg_last, cfg_pec_en, cfg_aux_pec, cfg_aux_blk;
  logic [2:0] cfg_prot;
  logic [7:0] cfg_cmd, cfg_addr, cfg_data0, cfg_data1, cfg_blkdat;
  logic [IW-1:0] blk_idx;
  logic op_done;
  logic [7:0] eng_set = 8'h00;
  logic eng_busy_clr = 1'b0, eng_done = 1'b0, eng_idx_step = 1'b0;
  logic [2:0] eng_dsel = 3'b000;
  logic [7:0] eng_dat = 8'h00;

  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbh_regbank #(.ADDR_W(AW), .BUF_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .start_pulse(start_pulse),
    .cfg_prot(cfg_prot), .cfg_last(cfg_last), .cfg_pec_en(cfg_pec_en),
    .cfg_aux_pec(cfg_aux_pec), .cfg_aux_blk(cfg_aux_blk), .cfg_cmd(cfg_cmd),
    .cfg_addr(cfg_addr), .cfg_data0(cfg_data0), .cfg_data1(cfg_data1),
    .cfg_blkdat(cfg_blkdat), .blk_idx(blk_idx), .op_done(op_done),
    .eng_set(eng_set), .eng_busy_clr(eng_busy_clr), .eng_done(eng_done),
    .eng_idx_step(eng_idx_step), .eng_dsel(eng_dsel), .eng_dat(eng_dat)
  );

  // {write, offset, data, expected read}
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h03, 8'h5A, 8'h00}, {1'b0, 8'h03, 8'h00, 8'h5A},
    {1'b1, 8'h04, 8'hA5, 8'h00}, {1'b0, 8'h04, 8'h00, 8'hA5},
    {1'b1, 8'h05, 8'h3C, 8'h00}, {1'b0, 8'h05, 8'h00, 8'h3C},
    {1'b1, 8'h06, 8'hC3, 8'h00}, {1'b0, 8'h06, 8'h00, 8'hC3},
    {1'b1, 8'h07, 8'h99, 8'h00}, {1'b0, 8'h07, 8'h00, 8'h99},
    {1'b1, 8'h0D, 8'hFF, 8'h00}, {1'b0, 8'h0D, 8'h00, 8'h03},
    {1'b1, 8'h02, 8'hBD, 8'h00}, {1'b0, 8'h02, 8'h00, 8'h1D},
    {1'b0, 8'h01, 8'h00, 8'h00}, {1'b0, 8'h08, 8'h00, 8'h00},
    {1'b0, 8'h0E, 8'h00, 8'h00}, {1'b0, 8'h0C, 8'h00, 8'h00},
    {1'b1, 8'h02, 8'h00, 8'h00}, {1'b0, 8'h02, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic step_idx(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eng_idx_step = 1'b1;
      @(negedge clk); eng_idx_step = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 start", start_pulse, 0);
    check("R1 idx", blk_idx, 0);
    check("R1 done", op_done, 1);
    rd(8'h00, v); check("R1 status", v, 8'h00);

    // R2 R5 R8 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][23:16], v);
        check("R2 R5 R8 table", v, VEC[i][7:0]);
      end
    end

    // R5 start
    wr(8'h02, 8'h41);
    check("R5 pulse", start_pulse, 1);
    check("R5 done clr", op_done, 0);
    @(negedge clk);
    check("R5 pulse once", start_pulse, 0);
    rd(8'h00, v); check("R5 busy", v, 8'h01);
    rd(8'h02, v); check("R5 readback", v, 8'h01);
    check("R7 busy only", irq, 0);

    // R7 interrupt from engine event
    @(negedge clk); eng_set = 8'h02;
    @(negedge clk); eng_set = 8'h00;
    check("R7 irq set", irq, 1);
    rd(8'h00, v); check("R7 status", v, 8'h03);

    // R3 write ones clear, busy kept
    wr(8'h00, 8'hFF);
    rd(8'h00, v); check("R3 busy kept", v, 8'h01);
    check("R3 irq drop", irq, 0);

    // R10 index advance and wrap
    step_idx(3);  check("R10 step", blk_idx, 3);
    step_idx(DEPTH - 3); check("R10 wrap", blk_idx, 0);
    step_idx(2);  check("R10 after wrap", blk_idx, 2);

    // R6 kill
    wr(8'h02, 8'h02);
    check("R6 idx", blk_idx, 0);
    check("R6 done", op_done, 1);
    check("R6 irq off", irq, 0);
    rd(8'h00, v); check("R6 status", v, 8'h10);
    wr(8'h02, 8'h01);
    check("R7 enable", irq, 1);
    wr(8'h00, 8'h10);
    check("R7 cleared", irq, 0);

    // R6 kill beats start in same write
    wr(8'h02, 8'h43);
    check("R6 kill over start done", op_done, 1);
    rd(8'h00, v); check("R6 kill over start", v, 8'h10);
    wr(8'h00, 8'h10);
    wr(8'h02, 8'h01);

    // R4 engine set beats same-cycle clear
    @(negedge clk);
    bus_addr = AW'(8'h00); bus_wdata = 8'h80; bus_wr = 1'b1; eng_set = 8'h80;
    @(negedge clk);
    bus_wr = 1'b0; eng_set = 8'h00;
    rd(8'h00, v); check("R4 set wins", v, 8'h80);
    check("R4 irq", irq, 1);
    wr(8'h00, 8'h80);
    rd(8'h00, v); check("R4 later clear", v, 8'h00);

    // R9 engine loads
    @(negedge clk);
    bus_addr = AW'(8'h05); bus_wdata = 8'h11; bus_wr = 1'b1;
    eng_dsel = 3'b001; eng_dat = 8'h77;
    @(negedge clk);
    bus_wr = 1'b0; eng_dsel = 3'b000;
    rd(8'h05, v); check("R9 engine wins", v, 8'h77);
    @(negedge clk); eng_dsel = 3'b110; eng_dat = 8'h42;
    @(negedge clk); eng_dsel = 3'b000;
    rd(8'h06, v); check("R9 data1", v, 8'h42);
    rd(8'h07, v); check("R9 block", v, 8'h42);

    // R11 engine busy clear and done
    wr(8'h02, 8'h41);
    rd(8'h00, v); check("R11 busy set", v, 8'h01);
    @(negedge clk); eng_busy_clr = 1'b1; eng_done = 1'b1;
    @(negedge clk); eng_busy_clr = 1'b0; eng_done = 1'b0;
    rd(8'h00, v); check("R11 busy clr", v, 8'h00);
    check("R11 done", op_done, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule